// File: doc/BRIEF.md
# Sequential Slice-Scanning Bit Length Finder

This block reports the effective bit length of a wide unsigned vector, that is, the position of its most significant one plus one. It is meant for places where the answer is not needed at once and logic area matters more than latency. The block holds one small slice encoder and feeds it a new slice of the captured vector on every clock.

A single-cycle start pulse, given while the block is idle, captures the input vector. On each following cycle the block examines one slice of the captured copy. It begins with the most significant slice and moves toward bit 0. It stops at the first slice that contains a one, then gives a one-cycle done pulse and presents the length. If the vector is all zero, the block scans every slice and reports length 0.

Top module: `vec_len_scan`

## Requirements
- R1: After reset, busy_o and done_o are low and length_o is 0.
- R2: A start_i pulse seen while the block is idle (busy_o and done_o both low) is accepted: busy_o is high in the next cycle and length_o reads 0 from that cycle until the result is posted.
- R3: Exactly one SLICE_W-bit slice is examined per cycle, beginning with the most significant slice. busy_o therefore stays high for NUM_SLICES - floor((L-1)/SLICE_W) cycles when the result L is nonzero, and for NUM_SLICES cycles when the vector is zero.
- R4: The reported length is the index of the highest set bit plus one. For example, a vector whose low byte is 00011010 with all other bits clear gives 5.
- R5: For an all-zero vector the reported length is 0, posted after NUM_SLICES scan cycles.
- R6: done_o is high for exactly one cycle, in the cycle right after the last scan cycle, and it is never high together with busy_o.
- R7: length_o keeps its value from the done pulse until the next start is accepted.
- R8: The vector is captured at the accepting start. Changes on data_i and start_i pulses while busy_o or done_o is high have no effect on the result or on the timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture data_i and begin a scan (taken only when idle) |
| data_i | input | DATA_W | Vector to measure |
| busy_o | output | 1 | A scan is in progress |
| done_o | output | 1 | One-cycle pulse: length_o has just been posted |
| length_o | output | $clog2(DATA_W+1) | Highest set-bit index plus one, 0 for a zero vector |

## Verification
The bench builds the block with the default parameters: a 1024-bit vector scanned in 16-bit slices, so 64 slices in all. At these values it can reach the full 64-cycle scan for a zero vector and a vector set only in bit 0. It also exercises the single-cycle scan for bit 1023 and the slice edges at bits 15 and 16, where a result moves from one slice to the next. The same defaults allow mid-scan disturbance of data_i and start_i over a long scan window, with the 8-bit example from R4 placed in the lowest slice.

// File: rtl/vec_len_scan_pkg.sv
package vec_len_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } scan_state_e;
endpackage

// File: rtl/slice_msb_enc.sv
module slice_msb_enc #(
  parameter int SLICE_W = 16,
  localparam int IDX_W = $clog2(SLICE_W)
) (
  input  logic [SLICE_W-1:0] slice_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < SLICE_W; i++) begin
      if (slice_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |slice_i;
endmodule

// File: rtl/slice_shifter.sv
module slice_shifter #(
  parameter int DATA_W  = 1024,
  parameter int SLICE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [SLICE_W-1:0] top_o
);
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (load_i)  data_q <= data_i;
    else if (shift_i) data_q <= data_q << SLICE_W;
  end

  // encoder always sees the current top slice; no wide mux needed
  assign top_o = data_q[DATA_W-1 -: SLICE_W];
endmodule

// File: rtl/lz_scan_ctrl.sv
module lz_scan_ctrl
  import vec_len_scan_pkg::*;
#(
  parameter int DATA_W  = 1024,
  parameter int SLICE_W = 16,
  localparam int NUM_SLICES = DATA_W / SLICE_W,
  localparam int PTR_W = $clog2(NUM_SLICES),
  localparam int IDX_W = $clog2(SLICE_W),
  localparam int LEN_W = $clog2(DATA_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             slice_any_i,
  input  logic [IDX_W-1:0] slice_idx_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [LEN_W-1:0] length_o
);
  scan_state_e state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             last_slice;

  assign last_slice = (ptr_q == '0);

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    len_d   = len_q;
    load_o  = 1'b0;
    shift_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          ptr_d   = PTR_W'(NUM_SLICES - 1);
          len_d   = '0;
          state_d = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (slice_any_i) begin
          len_d   = LEN_W'(ptr_q) * LEN_W'(SLICE_W) + LEN_W'(slice_idx_i) + LEN_W'(1);
          state_d = ST_DONE;
        end else if (last_slice) begin
          len_d   = '0;
          state_d = ST_DONE;
        end else begin
          shift_o = 1'b1;
          ptr_d   = ptr_q - PTR_W'(1);
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      len_q   <= len_d;
    end
  end

  assign busy_o   = (state_q == ST_SCAN);
  assign done_o   = (state_q == ST_DONE);
  assign length_o = len_q;
endmodule

// File: rtl/vec_len_scan.sv
module vec_len_scan #(
  parameter int DATA_W  = 1024,
  parameter int SLICE_W = 16,
  localparam int IDX_W = $clog2(SLICE_W),
  localparam int LEN_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [LEN_W-1:0]  length_o
);
  logic               load, shift, slice_any;
  logic [SLICE_W-1:0] top_slice;
  logic [IDX_W-1:0]   slice_idx;

  slice_shifter #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) i_shifter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .shift_i(shift),
    .data_i (data_i),
    .top_o  (top_slice)
  );

  slice_msb_enc #(.SLICE_W(SLICE_W)) i_enc (
    .slice_i(top_slice),
    .any_o  (slice_any),
    .idx_o  (slice_idx)
  );

  lz_scan_ctrl #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .slice_any_i(slice_any),
    .slice_idx_i(slice_idx),
    .load_o     (load),
    .shift_o    (shift),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .length_o   (length_o)
  );
endmodule

// File: rtl/vec_len_scan_chk.sv
module vec_len_scan_chk #(
  parameter int DATA_W  = 1024,
  parameter int SLICE_W = 16,
  localparam int NUM_SLICES = DATA_W / SLICE_W,
  localparam int CNT_W = $clog2(NUM_SLICES + 1),
  localparam int LEN_W = $clog2(DATA_W + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [LEN_W-1:0] length_o
);
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + CNT_W'(1);
    else             busy_cnt <= '0;
  end

  assert_start_taken_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !done_o) |=> (busy_o && length_o == '0));

  assert_scan_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_cnt < CNT_W'(NUM_SLICES)));

  assert_len_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    length_o <= LEN_W'(DATA_W));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  assert_done_after_scan_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));

  assert_len_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !$rose(busy_o)) |-> $stable(length_o));

  assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind vec_len_scan vec_len_scan_chk #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .length_o(length_o)
);

// File: tb/test_vec_len_scan.sv
module test_vec_len_scan;
  localparam int DATA_W  = 1024;
  localparam int SLICE_W = 16;
  localparam int NSL     = DATA_W / SLICE_W;
  localparam int LEN_W   = $clog2(DATA_W + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [DATA_W-1:0] data = '0;
  logic              busy, done;
  logic [LEN_W-1:0]  length;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vec_len_scan #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) i_vec_len_scan (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_i(data),
    .busy_o(busy), .done_o(done), .length_o(length)
  );

  function automatic int ref_len(input logic [DATA_W-1:0] v);
    for (int i = DATA_W - 1; i >= 0; i--) if (v[i]) return i + 1;
    return 0;
  endfunction

  function automatic int ref_scans(input int l);
    return (l == 0) ? NSL : NSL - (l - 1) / SLICE_W;
  endfunction

  // behavioural reference: 0 idle, 1 scanning, 2 done
  int m_state = 0, m_left = 0, m_len = 0, m_target = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_left = 0; m_len = 0; m_target = 0;
    end else begin
      cycles++;
      case (m_state)
        0: if (start) begin
             m_target = ref_len(data);
             m_left   = ref_scans(m_target);
             m_len    = 0;
             m_state  = 1;
           end
        1: begin
             m_left--;
             if (m_left == 0) begin m_len = m_target; m_state = 2; end
           end
        default: m_state = 0;
      endcase
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 busy", int'(busy), int'(m_state == 1));
      chk("R6 done", int'(done), int'(m_state == 2));
      chk("R4 length", int'(length), m_len);
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual %0d expected <150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // runs one measurement; returns observed busy cycles
  task automatic measure(input logic [DATA_W-1:0] v, input string req, output int nbusy);
    int exp;
    exp = ref_len(v);
    @(negedge clk);
    data = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nbusy = 0;
    while (!done && nbusy < NSL + 4) begin
      if (busy) nbusy++;
      @(negedge clk);
    end
    chk({req, " result"}, int'(length), exp);
    chk("R3 scan cycles", nbusy, ref_scans(exp));
  endtask

  initial begin
    int nb;
    logic [DATA_W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 length", int'(length), 0);

    v = '0; v[7:0] = 8'b0001_1010;
    measure(v, "R4 example", nb);
    v = '0; v[DATA_W-1] = 1'b1;
    measure(v, "R4 top bit", nb);
    chk("R3 top slice one cycle", nb, 1);
    v = '0;
    measure(v, "R5 zero", nb);
    chk("R5 full scan", nb, NSL);
    v = '0; v[0] = 1'b1;
    measure(v, "R4 bit0", nb);
    v = '0; v[15] = 1'b1; v[3] = 1'b1;
    measure(v, "R4 slice edge 15", nb);
    v = '0; v[16] = 1'b1;
    measure(v, "R4 slice edge 16", nb);
    v = {DATA_W{1'b1}};
    measure(v, "R4 all ones", nb);
    for (int k = 0; k < 6; k++) begin
      v = '0;
      for (int w = 0; w < DATA_W / 32; w++) v[w*32 +: 32] = $urandom;
      v = v >> ($urandom % DATA_W);
      measure(v, "R4 random", nb);
    end

    // R8: disturb inputs during a long scan
    v = '0; v[5] = 1'b1;
    @(negedge clk);
    data = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    data = {DATA_W{1'b1}}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    data = '0;
    while (!done && cycles < 140000) @(negedge clk);
    chk("R8 result unaffected", int'(length), 6);
    start = 1'b1; data = {DATA_W{1'b1}};   // start during done: ignored
    @(negedge clk);
    start = 1'b0;
    chk("R8 start in done ignored", int'(busy), 0);

    // R7: hold, then cleared on new start
    repeat (5) @(negedge clk);
    chk("R7 length holds", int'(length), 6);
    v = '0; v[100] = 1'b1;
    data = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", int'(busy), 1);
    chk("R7 length cleared", int'(length), 0);
    while (!done && cycles < 140000) @(negedge clk);
    chk("R4 bit100", int'(length), 101);
    @(negedge clk);
    chk("R6 done one cycle", int'(done), 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule